// File: doc/BRIEF.md
# Non-blocking load miss tracker

This block keeps track of loads that passed address translation but missed in the data cache. When such a load is accepted, it takes a tracking slot that holds its cache line, the word it wants from that line and its destination register. The load instruction can then leave the pipeline at once. A scoreboard built from the slots tells decode whether either of its two source reads names a register that is still waiting for memory. Only those reads stall. Instructions that do not read a pending register keep flowing.

When the cache returns a line, every slot waiting on that line writes its word back on its own write-back port, and all of them free in the same cycle. Before a buffered store commits, the store queue probes the tracker with the store's line. The store may commit whenever no slot holds that line, even if older loads to other lines are still outstanding. This is what allows a later store to become visible before an earlier load completes. A store to a pending line is held until that line's fill has retired the slot.

A slot can only be released by its fill. No flush or cancel path exists, because a tracked load can no longer fault. The reset input is expected to be asserted asynchronously and released in step with the clock by the surrounding reset logic.

Top module: `ldmiss_buf`

## Requirements
- R1: After reset, no slot is occupied: `ld_buf_full` is low, `rd_stall` is low for any read, `st_commit_ok` is high for any valid probe, and `wb_valid` is all zero.
- R2: `rd_stall` is high in a cycle exactly when a valid read port names the destination register of a waiting slot, or the destination register of a load miss accepted in that same cycle. Otherwise it is low.
- R3: `ld_buf_full` is high exactly when all SLOTS slots are occupied. A miss presented while the buffer is full is not accepted and creates no slot, so its register never stalls.
- R4: `st_commit_ok` is high exactly when `st_probe_valid` is high and no occupied slot holds the probed line. Line addresses are byte addresses divided by LINE_BYTES (64). The probe compares against the slot state held before the clock edge, so a store to a line is still held in the cycle that line's fill arrives, and is permitted from the next cycle.
- R5: In a fill cycle, every waiting slot whose line equals `fill_line` raises `wb_valid[slot]` in that same cycle. Its `wb_dst` slice carries the slot's destination register, and its `wb_data` slice carries `fill_data[word*32 +: 32]`, where `word` is the recorded word index. The slot is free after the clock edge.
- R6: Two or more slots that wait on the same line each keep their own entry, and all of them write back and free on a single fill.
- R7: When a new miss is accepted with the same destination register as a waiting slot, the older slot is superseded. It stays occupied and still frees on its own line's fill, but it never writes back and no longer causes a stall.
- R8: An accepted miss takes the lowest-numbered free slot. Slot i reports on `wb_valid[i]` and on the i-th slices of `wb_dst` and `wb_data`.
- R9: A fill whose line matches no occupied slot produces no write-back and leaves every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ld_miss_valid | input | 1 | A translated load missed the cache |
| ld_miss_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the missing load |
| ld_miss_word | input | log2(LINE_BYTES*8/DATA_W) | Word index within the line |
| ld_miss_dst | input | log2(NREGS) | Destination register of the load |
| ld_buf_full | output | 1 | All slots occupied; the load stage must hold |
| rd_a_valid | input | 1 | Decode source A is read |
| rd_a_idx | input | log2(NREGS) | Decode source A register |
| rd_b_valid | input | 1 | Decode source B is read |
| rd_b_idx | input | log2(NREGS) | Decode source B register |
| rd_stall | output | 1 | A source read names a pending register |
| fill_valid | input | 1 | Cache line returned |
| fill_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the returned data |
| fill_data | input | LINE_BYTES*8 | Returned line contents |
| wb_valid | output | SLOTS | Per-slot register write enable |
| wb_dst | output | SLOTS*log2(NREGS) | Per-slot write-back register |
| wb_data | output | SLOTS*DATA_W | Per-slot write-back word |
| st_probe_valid | input | 1 | A buffered store asks to commit |
| st_probe_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the store |
| st_commit_ok | output | 1 | Store may commit this cycle |

## Verification
The occupancy sweep fills the buffer from one to four slots, reads every one of the 32 registers and probes both tracked and untracked lines. This separates a scoreboard that follows the destinations from one that stalls too much or too little, and a probe that matches lines from one that holds every store. Fills are returned out of allocation order, which shows whether the write-back port and word select follow the slot rather than the order of arrival. Directed patterns cover two misses to one line, two misses to one register in both fill orders, a miss presented while full, a fill to an idle line, and a probe in the same cycle as the fill of its line. Each of these tells one specific misbehaviour apart from correct operation.

// File: rtl/ldmb_pkg.sv
package ldmb_pkg;
  // Lifecycle of one tracking slot.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,  // free
    SLOT_WAIT  = 2'd1,  // waiting, will write back
    SLOT_MUTED = 2'd2   // waiting, superseded by a younger miss to its register
  } slot_state_e;
endpackage

// File: rtl/ldmb_pick.sv
module ldmb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] grant
);
  // lowest index wins: a running "already granted" chain
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = free_vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | free_vec[i];
  end
endmodule

// File: rtl/ldmb_slot.sv
module ldmb_slot
  import ldmb_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int WSEL_W = 4,
  parameter int RIDX_W = 5,
  parameter int DATA_W = 32,
  parameter int FILL_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [WSEL_W-1:0] alloc_wsel,
  input  logic [RIDX_W-1:0] alloc_dst,
  input  logic              new_miss,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [FILL_W-1:0] fill_data,
  input  logic [LINE_W-1:0] probe_line,
  output logic              occupied,
  output logic              live,
  output logic              probe_hit,
  output logic              wb_en,
  output logic [RIDX_W-1:0] dst_o,
  output logic [DATA_W-1:0] wb_word
);
  slot_state_e       state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [RIDX_W-1:0] dst_q;
  logic              fill_hit;

  assign occupied = (state_q != SLOT_IDLE);
  assign live     = (state_q == SLOT_WAIT);
  assign fill_hit = occupied && fill_valid && (fill_line == line_q);

  // next state: alloc only reaches an idle slot, fill retires, a younger
  // miss to the same register silences the write-back
  always_comb begin
    state_d = state_q;
    if (alloc_en) begin
      state_d = SLOT_WAIT;
    end else if (fill_hit) begin
      state_d = SLOT_IDLE;
    end else if (live && new_miss && (alloc_dst == dst_q)) begin
      state_d = SLOT_MUTED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // payload registers, loaded only on allocation
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line_q <= alloc_line;
      wsel_q <= alloc_wsel;
      dst_q  <= alloc_dst;
    end
  end

  assign probe_hit = occupied && (probe_line == line_q);
  assign wb_en     = fill_hit && live;
  assign dst_o     = dst_q;
  assign wb_word   = fill_data[wsel_q*DATA_W +: DATA_W];
endmodule

// File: rtl/ldmb_hazard.sv
module ldmb_hazard #(
  parameter int N      = 4,
  parameter int NREGS  = 32,
  parameter int RIDX_W = 5
) (
  input  logic [N-1:0]        live_vec,
  input  logic [N*RIDX_W-1:0] dst_flat,
  input  logic                new_miss,
  input  logic [RIDX_W-1:0]   miss_dst,
  input  logic                rd_a_valid,
  input  logic [RIDX_W-1:0]   rd_a_idx,
  input  logic                rd_b_valid,
  input  logic [RIDX_W-1:0]   rd_b_idx,
  input  logic                probe_valid,
  input  logic [N-1:0]        probe_hit_vec,
  output logic [NREGS-1:0]    pending,
  output logic                rd_stall,
  output logic                commit_ok
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic held;
    always_comb begin
      held = new_miss && (miss_dst == RIDX_W'(r));
      for (int s = 0; s < N; s++) begin
        held = held | (live_vec[s] && (dst_flat[s*RIDX_W +: RIDX_W] == RIDX_W'(r)));
      end
    end
    assign pending[r] = held;
  end

  assign rd_stall  = (rd_a_valid && pending[rd_a_idx]) ||
                     (rd_b_valid && pending[rd_b_idx]);
  assign commit_ok = probe_valid && !(|probe_hit_vec);
endmodule

// File: rtl/ldmiss_buf.sv
module ldmiss_buf #(
  parameter int SLOTS      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DATA_W     = 32,
  parameter int NREGS      = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int FILL_W = LINE_BYTES * 8,
  localparam int WORDS  = FILL_W / DATA_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_miss_valid,
  input  logic [LINE_W-1:0]       ld_miss_line,
  input  logic [WSEL_W-1:0]       ld_miss_word,
  input  logic [RIDX_W-1:0]       ld_miss_dst,
  output logic                    ld_buf_full,
  input  logic                    rd_a_valid,
  input  logic [RIDX_W-1:0]       rd_a_idx,
  input  logic                    rd_b_valid,
  input  logic [RIDX_W-1:0]       rd_b_idx,
  output logic                    rd_stall,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  input  logic [FILL_W-1:0]       fill_data,
  output logic [SLOTS-1:0]        wb_valid,
  output logic [SLOTS*RIDX_W-1:0] wb_dst,
  output logic [SLOTS*DATA_W-1:0] wb_data,
  input  logic                    st_probe_valid,
  input  logic [LINE_W-1:0]       st_probe_line,
  output logic                    st_commit_ok
);
  logic [SLOTS-1:0]        slot_occ;
  logic [SLOTS-1:0]        slot_live;
  logic [SLOTS-1:0]        slot_probe_hit;
  logic [SLOTS-1:0]        slot_grant;
  logic [SLOTS-1:0]        slot_alloc;
  logic [SLOTS*RIDX_W-1:0] slot_dst;
  logic [NREGS-1:0]        reg_pending;
  logic                    miss_accept;

  assign ld_buf_full = &slot_occ;
  assign miss_accept = ld_miss_valid && !ld_buf_full;

  ldmb_pick #(.N(SLOTS)) pick_i (
    .free_vec (~slot_occ),
    .grant    (slot_grant)
  );

  assign slot_alloc = miss_accept ? slot_grant : '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    ldmb_slot #(
      .LINE_W (LINE_W),
      .WSEL_W (WSEL_W),
      .RIDX_W (RIDX_W),
      .DATA_W (DATA_W),
      .FILL_W (FILL_W)
    ) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (slot_alloc[i]),
      .alloc_line (ld_miss_line),
      .alloc_wsel (ld_miss_word),
      .alloc_dst  (ld_miss_dst),
      .new_miss   (miss_accept),
      .fill_valid (fill_valid),
      .fill_line  (fill_line),
      .fill_data  (fill_data),
      .probe_line (st_probe_line),
      .occupied   (slot_occ[i]),
      .live       (slot_live[i]),
      .probe_hit  (slot_probe_hit[i]),
      .wb_en      (wb_valid[i]),
      .dst_o      (slot_dst[i*RIDX_W +: RIDX_W]),
      .wb_word    (wb_data[i*DATA_W +: DATA_W])
    );
  end

  assign wb_dst = slot_dst;

  ldmb_hazard #(
    .N      (SLOTS),
    .NREGS  (NREGS),
    .RIDX_W (RIDX_W)
  ) hazard_i (
    .live_vec      (slot_live),
    .dst_flat      (slot_dst),
    .new_miss      (miss_accept),
    .miss_dst      (ld_miss_dst),
    .rd_a_valid    (rd_a_valid),
    .rd_a_idx      (rd_a_idx),
    .rd_b_valid    (rd_b_valid),
    .rd_b_idx      (rd_b_idx),
    .probe_valid   (st_probe_valid),
    .probe_hit_vec (slot_probe_hit),
    .pending       (reg_pending),
    .rd_stall      (rd_stall),
    .commit_ok     (st_commit_ok)
  );
endmodule

// File: rtl/ldmb_checks.sv
module ldmb_checks #(
  parameter int SLOTS  = 4,
  parameter int LINE_W = 26,
  parameter int RIDX_W = 5,
  parameter int NREGS  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_miss_valid,
  input logic [LINE_W-1:0] ld_miss_line,
  input logic [RIDX_W-1:0] ld_miss_dst,
  input logic              ld_buf_full,
  input logic              fill_valid,
  input logic [SLOTS-1:0]  wb_valid,
  input logic              st_probe_valid,
  input logic [LINE_W-1:0] st_probe_line,
  input logic              st_commit_ok,
  input logic [SLOTS-1:0]  occ,
  input logic [NREGS-1:0]  pending
);
  AST_WB_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_valid) |-> fill_valid);  // R5

  AST_FULL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_buf_full && !fill_valid) |=> (ld_buf_full && $stable(occ)));  // R3

  AST_NO_GROWTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_miss_valid |=> ($countones(occ) <= $past($countones(occ))));  // R3

  AST_NEW_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_miss_valid && !ld_buf_full) |=>
      !(st_probe_valid && (st_probe_line == $past(ld_miss_line)) && st_commit_ok));  // R4

  AST_NEW_DST_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_miss_valid && !ld_buf_full) |=> pending[$past(ld_miss_dst)]);  // R2

  AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (wb_valid == '0));  // R9
endmodule

bind ldmiss_buf ldmb_checks #(
  .SLOTS  (SLOTS),
  .LINE_W (LINE_W),
  .RIDX_W (RIDX_W),
  .NREGS  (NREGS)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ld_miss_valid  (ld_miss_valid),
  .ld_miss_line   (ld_miss_line),
  .ld_miss_dst    (ld_miss_dst),
  .ld_buf_full    (ld_buf_full),
  .fill_valid     (fill_valid),
  .wb_valid       (wb_valid),
  .st_probe_valid (st_probe_valid),
  .st_probe_line  (st_probe_line),
  .st_commit_ok   (st_commit_ok),
  .occ            (slot_occ),
  .pending        (reg_pending)
);

// File: tb/ldmiss_buf_tb_top.sv
module ldmiss_buf_tb_top;
  localparam int N   = 4;
  localparam int LW  = 26;
  localparam int WW  = 4;
  localparam int RW  = 5;
  localparam int DW  = 32;
  localparam int FW  = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ld_miss_valid;
  logic [LW-1:0] ld_miss_line;
  logic [WW-1:0] ld_miss_word;
  logic [RW-1:0] ld_miss_dst;
  logic          ld_buf_full;
  logic          rd_a_valid, rd_b_valid;
  logic [RW-1:0] rd_a_idx, rd_b_idx;
  logic          rd_stall;
  logic          fill_valid;
  logic [LW-1:0] fill_line;
  logic [FW-1:0] fill_data;
  logic [N-1:0]    wb_valid;
  logic [N*RW-1:0] wb_dst;
  logic [N*DW-1:0] wb_data;
  logic          st_probe_valid;
  logic [LW-1:0] st_probe_line;
  logic          st_commit_ok;

  ldmiss_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_miss_valid(ld_miss_valid), .ld_miss_line(ld_miss_line),
    .ld_miss_word(ld_miss_word), .ld_miss_dst(ld_miss_dst),
    .ld_buf_full(ld_buf_full),
    .rd_a_valid(rd_a_valid), .rd_a_idx(rd_a_idx),
    .rd_b_valid(rd_b_valid), .rd_b_idx(rd_b_idx), .rd_stall(rd_stall),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
    .st_probe_valid(st_probe_valid), .st_probe_line(st_probe_line),
    .st_commit_ok(st_commit_ok)
  );

  int checks = 0;
  int errors = 0;

  // reference model, built from the requirements
  bit          mv [N];
  bit          ml [N];
  logic [LW-1:0] mline [N];
  logic [RW-1:0] mdst [N];
  logic [WW-1:0] mword [N];

  function automatic logic [DW-1:0] word_of(logic [LW-1:0] line, int w);
    return 32'hC0DE0000 + DW'(line) * 32'h10 + DW'(w);
  endfunction

  function automatic logic [FW-1:0] pattern(logic [LW-1:0] line);
    logic [FW-1:0] d;
    for (int w = 0; w < FW / DW; w++) d[w*DW +: DW] = word_of(line, w);
    return d;
  endfunction

  task automatic check(string tag, string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    ld_miss_valid = 0; ld_miss_line = '0; ld_miss_word = '0; ld_miss_dst = '0;
    rd_a_valid = 0; rd_a_idx = '0; rd_b_valid = 0; rd_b_idx = '0;
    fill_valid = 0; fill_line = '0; fill_data = '0;
    st_probe_valid = 0; st_probe_line = '0;
  endtask

  // compare outputs against the model, then advance one clock
  task automatic step(string tag);
    bit full, acc, stall, cok;
    int pick;
    logic [N-1:0] ev;
    #1;
    full = 1;
    for (int i = 0; i < N; i++) if (!mv[i]) full = 0;
    acc = ld_miss_valid && !full;
    pick = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) pick = i;
    stall = 0;
    for (int i = 0; i < N; i++) begin
      if (mv[i] && ml[i] && rd_a_valid && mdst[i] == rd_a_idx) stall = 1;
      if (mv[i] && ml[i] && rd_b_valid && mdst[i] == rd_b_idx) stall = 1;
    end
    if (acc && rd_a_valid && ld_miss_dst == rd_a_idx) stall = 1;
    if (acc && rd_b_valid && ld_miss_dst == rd_b_idx) stall = 1;
    cok = st_probe_valid;
    for (int i = 0; i < N; i++) if (mv[i] && mline[i] == st_probe_line) cok = 0;
    for (int i = 0; i < N; i++) ev[i] = mv[i] && ml[i] && fill_valid && mline[i] == fill_line;
    check(tag, "full", 128'(ld_buf_full), 128'(full));
    check(tag, "stall", 128'(rd_stall), 128'(stall));
    check(tag, "commit_ok", 128'(st_commit_ok), 128'(cok));
    check(tag, "wb_valid", 128'(wb_valid), 128'(ev));
    for (int i = 0; i < N; i++) if (ev[i]) begin
      check(tag, "wb_dst", 128'(wb_dst[i*RW +: RW]), 128'(mdst[i]));
      check(tag, "wb_data", 128'(wb_data[i*DW +: DW]), 128'(word_of(mline[i], int'(mword[i]))));
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (mv[i] && fill_valid && mline[i] == fill_line) mv[i] = 0;
      else if (mv[i] && ml[i] && acc && mdst[i] == ld_miss_dst) ml[i] = 0;
    end
    if (acc) begin
      mv[pick] = 1; ml[pick] = 1; mline[pick] = ld_miss_line;
      mdst[pick] = ld_miss_dst; mword[pick] = ld_miss_word;
    end
    @(negedge clk);
  endtask

  task automatic do_alloc(logic [LW-1:0] line, logic [WW-1:0] w, logic [RW-1:0] d, string tag);
    idle();
    ld_miss_valid = 1; ld_miss_line = line; ld_miss_word = w; ld_miss_dst = d;
    step(tag);
    idle();
  endtask

  task automatic do_fill(logic [LW-1:0] line, string tag);
    idle();
    fill_valid = 1; fill_line = line; fill_data = pattern(line);
    step(tag);
    idle();
  endtask

  task automatic read_reg(logic [RW-1:0] r, string tag);
    idle();
    rd_a_valid = 1; rd_a_idx = r;
    step(tag);
    idle();
  endtask

  task automatic probe(logic [LW-1:0] line, string tag);
    idle();
    st_probe_valid = 1; st_probe_line = line;
    step(tag);
    idle();
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = 0; end
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: empty after reset, probes and reads all clear
    st_probe_valid = 1; st_probe_line = 26'h55; rd_a_valid = 1; rd_a_idx = 3;
    rd_b_valid = 1; rd_b_idx = 0;
    step("R1");
    idle();

    // R2: stall only on the pending register, including same-cycle alloc
    idle();
    ld_miss_valid = 1; ld_miss_line = 26'h100; ld_miss_word = 4'd2; ld_miss_dst = 5'd5;
    rd_b_valid = 1; rd_b_idx = 5'd5;
    step("R2");
    idle();
    read_reg(5'd5, "R2");
    read_reg(5'd6, "R2");
    do_fill(26'h100, "R5");
    read_reg(5'd5, "R2");

    // sweep occupancy 1..4: every register, several lines, out-of-order fills
    for (int n = 1; n <= N; n++) begin
      for (int k = 0; k < n; k++)
        do_alloc(LW'(26'h200 + n * 8 + k), WW'((k * 5 + n) % 16), RW'((n * 7 + k * 3) % 32), "R8");
      for (int r = 0; r < 32; r++) read_reg(RW'(r), "R2");
      for (int k = 0; k < 6; k++) probe(LW'(26'h200 + n * 8 + k), "R4");
      for (int k = n - 1; k >= 0; k--) do_fill(LW'(26'h200 + n * 8 + k), "R5");
    end

    // R3: full, extra miss refused
    for (int k = 0; k < N; k++) do_alloc(LW'(26'h300 + k), WW'(k), RW'(10 + k), "R3");
    do_alloc(26'h3F0, 4'd1, 5'd20, "R3");
    read_reg(5'd20, "R3");
    probe(26'h3F0, "R3");
    // R9: fill to an untracked line changes nothing
    do_fill(26'h3F0, "R9");
    read_reg(5'd12, "R9");
    probe(26'h302, "R9");
    // R8: free slots 1 and 2, next miss lands in slot 1
    do_fill(26'h301, "R8");
    do_fill(26'h302, "R8");
    do_alloc(26'h3A0, 4'd15, 5'd21, "R8");
    do_fill(26'h3A0, "R8");
    do_fill(26'h300, "R5");
    do_fill(26'h303, "R5");

    // R6: two misses to one line complete together
    do_alloc(26'h400, 4'd3, 5'd1, "R6");
    do_alloc(26'h400, 4'd9, 5'd2, "R6");
    do_fill(26'h400, "R6");
    read_reg(5'd2, "R6");

    // R7: same destination twice, older filled first then younger first
    do_alloc(26'h500, 4'd4, 5'd9, "R7");
    do_alloc(26'h501, 4'd6, 5'd9, "R7");
    do_fill(26'h500, "R7");
    read_reg(5'd9, "R7");
    do_fill(26'h501, "R7");
    do_alloc(26'h510, 4'd7, 5'd11, "R7");
    do_alloc(26'h511, 4'd8, 5'd11, "R7");
    do_fill(26'h511, "R7");
    read_reg(5'd11, "R7");
    probe(26'h510, "R7");
    do_fill(26'h510, "R7");

    // R4: probe in the fill cycle is held, next cycle permitted
    do_alloc(26'h600, 4'd0, 5'd30, "R4");
    idle();
    fill_valid = 1; fill_line = 26'h600; fill_data = pattern(26'h600);
    st_probe_valid = 1; st_probe_line = 26'h600;
    step("R4");
    idle();
    probe(26'h600, "R4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule